// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Takeover and Pin Interrupts

This block drives a group of bidirectional pads (eight by default) from a small register file. Software picks each pin's direction. When a pin drives, its output bit sets the level. When a pin listens, the same output bit turns a weak pullup on or off. The pad side gives one output value, one output enable and one pullup enable per pin. It also takes back the raw pad level. The pad cells themselves are outside this block.

Each pin can be handed to a peripheral. Setting its takeover bit passes the pin's output value and output enable to the peripheral's signals and turns off the pullup. The general-purpose settings stay stored but have no effect while the takeover bit is set. The pad level always passes through a two-flop synchronizer. The synchronized value is readable on the bus and is also handed to the peripherals.

When the interrupt variant is built (`IRQ_EN = 1`), each pin watches for either a rising or a falling edge, chosen per pin. A detected edge sets a sticky per-pin flag. The flag is set even when that pin's interrupt is masked. The single interrupt output is the OR of all flags that are both set and enabled. Flags clear only when software writes 1 to them.

Top module: `gpio_port`

## Requirements
- R1: After reset every pin is a high-impedance input: pad_oe = 0, pad_pu = 0 and irq = 0. Every readable register returns 0.
- R2: When a pin's direction bit is 1 (register 0) and its takeover bit is 0, pad_oe is 1 and pad_out equals that pin's output bit (register 1).
- R3: When a pin's direction bit is 0 and its takeover bit is 0, pad_oe is 0 and pad_pu equals that pin's output bit. pad_oe and pad_pu are never both 1 on a pin.
- R4: When a pin's takeover bit is 1 (register 3), pad_out follows alt_out and pad_oe follows alt_oe, and pad_pu is 0. The stored direction and output bits read back unchanged.
- R5: The input register (register 2) and alt_in return the pad level two clock edges after it was sampled, whatever the direction and takeover settings are.
- R6: An edge-select bit of 1 (register 4) makes the pin flag on a rising synchronized edge. A bit of 0 flags a falling edge. The flag (register 6) reads 1 three clock edges after the pad changes.
- R7: A flag is set even when its enable bit (register 5) is 0. irq is 1 exactly when some pin has both its flag and its enable set.
- R8: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. If a new edge and a clearing write fall in the same cycle, the flag stays set.
- R9: Writes to the input register (address 2) are ignored. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW (3) | Register address |
| bus_wdata | input | W (8) | Write data |
| bus_rdata | output | W (8) | Read data, combinational from bus_addr |
| pad_in | input | W (8) | Raw pad levels |
| pad_out | output | W (8) | Pad drive values |
| pad_oe | output | W (8) | Pad output enables |
| pad_pu | output | W (8) | Weak pullup enables |
| alt_out | input | W (8) | Peripheral drive values |
| alt_oe | input | W (8) | Peripheral output enables |
| alt_in | output | W (8) | Synchronized pad levels for peripherals |
| irq | output | 1 | Port interrupt request |

## Verification
Two things can land on the same clock edge: a pin's flag being set by a detected edge, and software writing 1 to clear that same flag. The bench changes a pad at a falling clock edge. It then waits two rising edges and issues the clearing write so that it takes effect on the third rising edge, which is exactly when the edge detector reports. It judges the outcome by reading the flag afterwards. The flag must still read 1, and a second clearing write on a quiet cycle must then remove it.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W      = 8,
  parameter int AW     = 3,
  parameter bit IRQ_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_pu,
  input  logic [W-1:0]  alt_out,
  input  logic [W-1:0]  alt_oe,
  output logic [W-1:0]  alt_in,
  output logic          irq
);

  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_OUT  = AW'(1);
  localparam logic [AW-1:0] A_IN   = AW'(2);
  localparam logic [AW-1:0] A_ALT  = AW'(3);
  localparam logic [AW-1:0] A_ESEL = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);
  localparam logic [AW-1:0] A_FLAG = AW'(6);

  logic [W-1:0] sync1, sync2, sync3;
  logic [W-1:0] dir_q, out_q, alt_q;
  logic [W-1:0] esel_q, ien_q, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= pad_in;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      alt_q <= '0;
    end else if (bus_we) begin
      if (bus_addr == A_DIR) dir_q <= bus_wdata;
      if (bus_addr == A_OUT) out_q <= bus_wdata;
      if (bus_addr == A_ALT) alt_q <= bus_wdata;
    end
  end

  generate
    if (IRQ_EN) begin : g_irq
      logic [W-1:0] hit, clr;
      assign hit = (esel_q & sync2 & ~sync3) | (~esel_q & ~sync2 & sync3);
      assign clr = (bus_we && bus_addr == A_FLAG) ? bus_wdata : '0;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          esel_q <= '0;
          ien_q  <= '0;
          flag_q <= '0;
        end else begin
          if (bus_we && bus_addr == A_ESEL) esel_q <= bus_wdata;
          if (bus_we && bus_addr == A_IEN)  ien_q  <= bus_wdata;
          flag_q <= (flag_q & ~clr) | hit;
        end
      end
      assign irq = |(flag_q & ien_q);
    end else begin : g_noirq
      assign esel_q = '0;
      assign ien_q  = '0;
      assign flag_q = '0;
      assign irq    = 1'b0;
    end
  endgenerate

  assign pad_oe  = (alt_q & alt_oe)  | (~alt_q & dir_q);
  assign pad_out = (alt_q & alt_out) | (~alt_q & out_q);
  assign pad_pu  = ~alt_q & ~dir_q & out_q;
  assign alt_in  = sync2;

  always_comb begin
    case (bus_addr)
      A_DIR:   bus_rdata = dir_q;
      A_OUT:   bus_rdata = out_q;
      A_IN:    bus_rdata = sync2;
      A_ALT:   bus_rdata = alt_q;
      A_ESEL:  bus_rdata = esel_q;
      A_IEN:   bus_rdata = ien_q;
      A_FLAG:  bus_rdata = flag_q;
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  pad_in,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  pad_pu,
  input logic [W-1:0]  alt_in,
  input logic [W-1:0]  flag_q,
  input logic          irq
);

  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd0) |-> (pad_oe == '0 && pad_pu == '0 && !irq));

  a_r3_no_drive_and_pull: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & pad_pu) == '0);

  a_r5_sync_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> (alt_in == $past(pad_in, 2)));

  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd1 && !($past(bus_we) && $past(bus_addr) == AW'(6)))
      |-> ((~flag_q & $past(flag_q)) == '0));

endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .pad_in(pad_in), .pad_oe(pad_oe), .pad_pu(pad_pu), .alt_in(alt_in),
  .flag_q(flag_q), .irq(irq)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  logic [W-1:0]  bus_rdata;
  logic [W-1:0]  pad_in = '0;
  logic [W-1:0]  pad_out, pad_oe, pad_pu, alt_in;
  logic [W-1:0]  alt_out = '0;
  logic [W-1:0]  alt_oe = '0;
  logic          irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port #(.W(W), .AW(AW), .IRQ_EN(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pads(input logic [W-1:0] v);
    @(negedge clk);
    pad_in = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic t_reset;
    logic [W-1:0] d;
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    for (int a = 0; a < 8; a++) begin
      rd(AW'(a), d);
      check("R1 reg", d, 8'h00);
    end
  endtask

  task automatic t_gp_pins;
    logic [W-1:0] d;
    wr(AW'(0), 8'hF0);
    wr(AW'(1), 8'hA5);
    #2;
    check("R2 pad_oe", pad_oe, 8'hF0);
    check("R2 pad_out upper", pad_out & 8'hF0, 8'hA0);
    check("R3 pad_pu", pad_pu, 8'h05);
    check("R3 no oe+pu", pad_oe & pad_pu, 8'h00);
  endtask

  task automatic t_takeover;
    logic [W-1:0] d;
    alt_oe = 8'hFF; alt_out = 8'h08;
    wr(AW'(3), 8'h0C);
    #2;
    check("R4 pad_oe", pad_oe, 8'hFC);
    check("R4 pad_out", pad_out, 8'hA9);
    check("R4 pad_pu", pad_pu, 8'h01);
    rd(AW'(0), d); check("R4 dir kept", d, 8'hF0);
    rd(AW'(1), d); check("R4 out kept", d, 8'hA5);
    alt_oe = 8'h00;
    #1 check("R4 alt_oe low", pad_oe, 8'hF0);
    wr(AW'(3), 8'h00);
  endtask

  task automatic t_input;
    logic [W-1:0] d;
    set_pads(8'h3C);
    edges(1);
    rd(AW'(2), d); check("R5 not yet", d, 8'h00);
    edges(1);
    rd(AW'(2), d); check("R5 in reg", d, 8'h3C);
    check("R5 alt_in", alt_in, 8'h3C);
    wr(AW'(2), 8'hFF);
    rd(AW'(2), d); check("R9 in write ignored", d, 8'h3C);
    rd(AW'(7), d); check("R9 addr7", d, 8'h00);
  endtask

  task automatic t_edges;
    logic [W-1:0] d;
    wr(AW'(6), 8'hFF);
    wr(AW'(4), 8'h0F);
    set_pads(8'hC3);
    edges(2);
    rd(AW'(6), d); check("R6 flag not yet", d, 8'h00);
    edges(1);
    rd(AW'(6), d); check("R6 flags", d, 8'h33);
    check("R7 masked irq", {7'd0, irq}, 8'h00);
    wr(AW'(5), 8'h02);
    #2 check("R7 irq on", {7'd0, irq}, 8'h01);
    wr(AW'(6), 8'h01);
    rd(AW'(6), d); check("R8 clear one", d, 8'h32);
    check("R7 irq still", {7'd0, irq}, 8'h01);
    wr(AW'(6), 8'h00);
    rd(AW'(6), d); check("R8 zero write", d, 8'h32);
    wr(AW'(6), 8'h02);
    rd(AW'(6), d); check("R8 clear enabled", d, 8'h30);
    check("R7 irq off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collision;
    logic [W-1:0] d;
    wr(AW'(6), 8'hFF);
    set_pads(8'hD3);
    edges(4);
    rd(AW'(6), d); check("R6 wrong edge ignored", d, 8'h00);
    set_pads(8'hC3);
    repeat (2) @(posedge clk);
    wr(AW'(6), 8'h10);
    rd(AW'(6), d); check("R8 set wins", d, 8'h10);
    wr(AW'(6), 8'h10);
    rd(AW'(6), d); check("R8 later clear", d, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog got=%h exp=%h", 1'b1, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_gp_pins();
    t_takeover();
    t_input();
    t_edges();
    t_collision();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule